// File: doc/BRIEF.md
# Memory protection region checker

This block guards an address space with a small bank of programmable protection regions. Software sets the regions up over a narrow word-addressed register port. The port offers a read-only type word, a control word with a global enable, a region selector, and one base word and one attribute word per region. Each region covers a power-of-two span chosen by a five-bit size code. Its base is taken aligned to that span. The span is cut into eight equal slices, and any slice can be switched off on its own.

Each access request gives an address, a write flag, an instruction-fetch flag and a privilege flag. The checker looks at every enabled region at the same time. When regions overlap, the one with the highest number wins. The checker then applies that region's access-permission code and its no-execute bit. One cycle later it reports pass or fault, whether any region matched, and the number of the winning region. While the global enable is clear, every access passes.

Top module: `mprot_checker`

## Requirements
- R1: Register word 0 is read-only. It reads NREG in bits 15:8 and zero in every other bit, and a nonzero count means protection is present. Words 5 to 7 read zero. Writes to words 0 and 5 to 7 change nothing.
- R2: Bit 0 of word 1 is the global enable, and it reads back in bit 0 with the other bits zero. While it is clear, every access reports chk_fault=0, chk_hit=0 and chk_region=0, whatever the region settings.
- R3: Word 2 holds the region selector in its low log2(NREG) bits. Words 3 and 4 read and write the region it names.
- R4: A write to word 3 with bit 4 set stores the base into the region named by that write's bits log2(NREG)-1:0, and also loads that number into the selector. With bit 4 clear, the write goes to the selected region.
- R5: Word 3 stores address bits 31:5, and bits 4:0 read back as {0, selector}. During matching, base bits below the region size are ignored.
- R6: Word 4 holds the following fields: enable in bit 0, size code in bits 5:1, slice-disable in bits 15:8, S/C/B in bits 18:16, type extension in bits 21:19, permission code in bits 26:24, and no-execute in bit 28. All other bits read zero.
- R7: A size code c of 4 or more covers 2^(c+1) bytes, with code 31 covering all 4 GB. A region with a code below 4 never matches.
- R8: When several enabled regions match, the highest-numbered one decides the result, and its number is reported on chk_region with chk_hit=1.
- R9: Slice k is the k-th eighth of the region, given by address bits c-0:c-2 above the slice size. When bit 8+k of the attribute word is set, the region does not cover slice k, and lower-numbered regions decide instead.
- R10: With the global enable set, an access that matches no region faults with chk_hit=0.
- R11: The permission code works as follows. 0 and 4 deny everything. 1 allows privileged read and write. 2 also allows unprivileged reads. 3 allows all accesses. 5 allows privileged reads only. 6 and 7 allow reads at both levels.
- R12: An instruction fetch counts as a read whatever the write flag says. A fetch that hits a region with no-execute set faults.
- R13: The results appear with chk_valid=1 on the clock after the edge that samples acc_valid=1. chk_valid is 0 after a cycle with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| acc_valid | input | 1 | Access request present |
| acc_addr | input | 32 | Access address |
| acc_write | input | 1 | 1 = write access |
| acc_fetch | input | 1 | 1 = instruction fetch |
| acc_priv | input | 1 | 1 = privileged access |
| chk_valid | output | 1 | Result present |
| chk_fault | output | 1 | Access denied |
| chk_hit | output | 1 | Some enabled region matched |
| chk_region | output | log2(NREG) | Winning region number, 0 when none |

## Verification
The register read path is combinational, so the bench compares reg_rdata one time unit after it drives reg_addr, in the same cycle. A register write takes effect at the next edge. An access result is registered, so it is due on the edge that samples the request. It is judged against the region settings as they stood before any write sampled at that same edge. The reference model computes the expectation before it applies that cycle's write. It then compares all four result outputs at the falling edge after the sampling edge, on every cycle, including idle ones.

// File: rtl/mprot_pkg.sv
package mprot_pkg;

    localparam int REG_AW = 3;
    localparam logic [REG_AW-1:0] RA_TYPE = 3'd0;
    localparam logic [REG_AW-1:0] RA_CTRL = 3'd1;
    localparam logic [REG_AW-1:0] RA_SEL  = 3'd2;
    localparam logic [REG_AW-1:0] RA_BASE = 3'd3;
    localparam logic [REG_AW-1:0] RA_ATTR = 3'd4;

    localparam int BASE_VALID_BIT = 4;
    localparam logic [31:0] ATTR_MASK = 32'h173F_FF3F;
    localparam logic [4:0]  MIN_SIZE_CODE = 5'd4;

    typedef struct packed {
        logic       xn;
        logic [2:0] ap;
        logic [2:0] tex;
        logic [2:0] scb;
        logic [7:0] srd;
        logic [4:0] size;
        logic       en;
    } region_attr_t;

    typedef struct packed {
        logic [26:0]  base_hi;
        region_attr_t attr;
    } region_cfg_t;

    // fields needed for address matching
    typedef struct packed {
        logic [26:0] base_hi;
        logic [7:0]  srd;
        logic [4:0]  size;
        logic        en;
    } region_match_t;

    // fields needed for the permission decision
    typedef struct packed {
        logic [2:0] ap;
        logic       xn;
    } region_perm_t;

    function automatic region_attr_t attr_from_word(input logic [31:0] w);
        region_attr_t a;
        a.en   = w[0];
        a.size = w[5:1];
        a.srd  = w[15:8];
        a.scb  = w[18:16];
        a.tex  = w[21:19];
        a.ap   = w[26:24];
        a.xn   = w[28];
        return a;
    endfunction

    function automatic logic [31:0] attr_to_word(input region_attr_t a);
        logic [31:0] w;
        w        = '0;
        w[0]     = a.en;
        w[5:1]   = a.size;
        w[15:8]  = a.srd;
        w[18:16] = a.scb;
        w[21:19] = a.tex;
        w[26:24] = a.ap;
        w[28]    = a.xn;
        return w;
    endfunction

    function automatic logic ap_permits(input logic [2:0] ap, input logic priv,
                                        input logic wr);
        logic ok;
        case (ap)
            3'd1:    ok = priv;
            3'd2:    ok = priv | ~wr;
            3'd3:    ok = 1'b1;
            3'd5:    ok = priv & ~wr;
            3'd6,
            3'd7:    ok = ~wr;
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/mprot_regs.sv
module mprot_regs
    import mprot_pkg::*;
#(
    parameter int NREG   = 8,
    parameter int RIDX_W = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        reg_wr,
    input  logic [REG_AW-1:0]           reg_addr,
    input  logic [31:0]                 reg_wdata,
    output logic [31:0]                 reg_rdata,
    output logic                        glob_en,
    output region_match_t [NREG-1:0]    mcfg,
    output region_perm_t  [NREG-1:0]    pcfg
);

    region_cfg_t [NREG-1:0] cfg_q;
    logic [RIDX_W-1:0]      sel_q;
    logic                   en_q;
    logic [RIDX_W-1:0]      base_tgt;

    assign base_tgt = reg_wdata[BASE_VALID_BIT] ? reg_wdata[RIDX_W-1:0] : sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            sel_q <= '0;
            en_q  <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: en_q  <= reg_wdata[0];
                RA_SEL:  sel_q <= reg_wdata[RIDX_W-1:0];
                RA_BASE: begin
                    cfg_q[base_tgt].base_hi <= reg_wdata[31:5];
                    if (reg_wdata[BASE_VALID_BIT])
                        sel_q <= reg_wdata[RIDX_W-1:0];
                end
                RA_ATTR: cfg_q[sel_q].attr <= attr_from_word(reg_wdata);
                default: ;
            endcase
        end
    end

    always_comb begin
        case (reg_addr)
            RA_TYPE: reg_rdata = {16'd0, 8'(NREG), 8'd0};
            RA_CTRL: reg_rdata = {31'd0, en_q};
            RA_SEL:  reg_rdata = 32'(sel_q);
            RA_BASE: reg_rdata = {cfg_q[sel_q].base_hi, 1'b0, 4'(sel_q)};
            RA_ATTR: reg_rdata = attr_to_word(cfg_q[sel_q].attr);
            default: reg_rdata = '0;
        endcase
    end

    assign glob_en = en_q;

    for (genvar r = 0; r < NREG; r++) begin : g_out
        assign mcfg[r] = '{base_hi: cfg_q[r].base_hi, srd: cfg_q[r].attr.srd,
                           size: cfg_q[r].attr.size, en: cfg_q[r].attr.en};
        assign pcfg[r] = '{ap: cfg_q[r].attr.ap, xn: cfg_q[r].attr.xn};
    end

    // R3: a selector write lands in the selector
    a_r3_select_load: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_SEL) |=> (sel_q == $past(reg_wdata[RIDX_W-1:0])));

    // R4: a base write with the override bit retargets the selector
    a_r4_override_sel: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_BASE && reg_wdata[BASE_VALID_BIT])
        |=> (sel_q == $past(reg_wdata[RIDX_W-1:0])));

    // R6: reserved attribute bits read zero
    a_r6_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == RA_ATTR) |-> ((reg_rdata & ~ATTR_MASK) == 32'd0));

    // R2: control write drives the global enable
    a_r2_enable_load: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RA_CTRL) |=> (glob_en == $past(reg_wdata[0])));

endmodule

// File: rtl/mprot_match.sv
module mprot_match
    import mprot_pkg::*;
(
    input  region_match_t cfg,
    input  logic [31:0]   addr,
    output logic          hit
);

    logic [5:0]  shamt;
    logic [32:0] span;
    logic [32:0] low;
    logic [31:0] mask;
    logic [4:0]  slice_sh;
    logic [31:0] shifted;
    logic [2:0]  slice;
    logic        in_span;

    always_comb begin
        shamt    = {1'b0, cfg.size} + 6'd1;
        span     = 33'd1 << shamt;
        low      = span - 33'd1;
        mask     = ~low[31:0];
        in_span  = (((addr ^ {cfg.base_hi, 5'd0}) & mask) == 32'd0);
        slice_sh = cfg.size - 5'd2;
        shifted  = addr >> slice_sh;
        slice    = shifted[2:0];
        hit      = cfg.en && (cfg.size >= MIN_SIZE_CODE) && in_span && !cfg.srd[slice];
    end

endmodule

// File: rtl/mprot_prio.sv
module mprot_prio #(
    parameter int NREG   = 8,
    parameter int RIDX_W = 3
) (
    input  logic [NREG-1:0]   hits,
    output logic              any,
    output logic [RIDX_W-1:0] idx
);

    always_comb begin
        any = |hits;
        idx = '0;
        for (int i = 0; i < NREG; i++)
            if (hits[i]) idx = RIDX_W'(i);
    end

endmodule

// File: rtl/mprot_checker.sv
module mprot_checker
    import mprot_pkg::*;
#(
    parameter int NREG = 8,
    localparam int RIDX_W = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              acc_valid,
    input  logic [31:0]       acc_addr,
    input  logic              acc_write,
    input  logic              acc_fetch,
    input  logic              acc_priv,
    output logic              chk_valid,
    output logic              chk_fault,
    output logic              chk_hit,
    output logic [RIDX_W-1:0] chk_region
);

    logic                     glob_en;
    region_match_t [NREG-1:0] mcfg;
    region_perm_t  [NREG-1:0] pcfg;
    logic [NREG-1:0]          hits;
    logic                     any_hit;
    logic [RIDX_W-1:0]        win_idx;
    region_perm_t             win_perm;
    logic                     eff_wr;
    logic                     deny;
    logic                     fault_d;
    logic                     hit_d;

    mprot_regs #(.NREG(NREG), .RIDX_W(RIDX_W)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .glob_en(glob_en),
        .mcfg(mcfg), .pcfg(pcfg)
    );

    for (genvar r = 0; r < NREG; r++) begin : g_rgn
        mprot_match u_match (.cfg(mcfg[r]), .addr(acc_addr), .hit(hits[r]));
    end

    mprot_prio #(.NREG(NREG), .RIDX_W(RIDX_W)) u_prio (
        .hits(hits), .any(any_hit), .idx(win_idx)
    );

    always_comb begin
        win_perm = pcfg[win_idx];
        eff_wr   = acc_write & ~acc_fetch;
        deny     = !ap_permits(win_perm.ap, acc_priv, eff_wr) || (acc_fetch && win_perm.xn);
        hit_d    = glob_en && any_hit;
        fault_d  = glob_en && (!any_hit || deny);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_valid  <= 1'b0;
            chk_fault  <= 1'b0;
            chk_hit    <= 1'b0;
            chk_region <= '0;
        end else begin
            chk_valid  <= acc_valid;
            chk_fault  <= acc_valid && fault_d;
            chk_hit    <= acc_valid && hit_d;
            chk_region <= (acc_valid && hit_d) ? win_idx : '0;
        end
    end

    // R13: one-cycle result timing
    a_r13_result_due: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> chk_valid);
    a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !chk_valid);

    // R2: disabled unit lets everything through
    a_r2_off_pass: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !glob_en) |=> (!chk_fault && !chk_hit));

    // R10: miss faults when enabled
    a_r10_miss_fault: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && glob_en && !any_hit) |=> (chk_fault && !chk_hit));

    // R8: the winner is a hitting region with no higher hitter
    a_r8_highest_wins: assert property (@(posedge clk) disable iff (rst)
        any_hit |-> (hits[win_idx] && ((hits >> win_idx) == NREG'(1))));

    // R12: fetch into a no-execute region faults
    a_r12_xn_fault: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && glob_en && any_hit && acc_fetch && win_perm.xn) |=> chk_fault);

    // R11: permission code 0 denies
    a_r11_ap0_deny: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && glob_en && any_hit && win_perm.ap == 3'd0) |=> chk_fault);

endmodule

// File: tb/test_mprot_checker.sv
module test_mprot_checker;

    localparam int NREG = 8;
    localparam int RW   = 3;

    logic          clk = 1'b0;
    logic          rst;
    logic          reg_wr;
    logic [2:0]    reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic          acc_valid;
    logic [31:0]   acc_addr;
    logic          acc_write;
    logic          acc_fetch;
    logic          acc_priv;
    logic          chk_valid;
    logic          chk_fault;
    logic          chk_hit;
    logic [RW-1:0] chk_region;

    always #2 clk = ~clk;

    mprot_checker #(.NREG(NREG)) i_mprot_checker (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_write(acc_write), .acc_fetch(acc_fetch),
        .acc_priv(acc_priv), .chk_valid(chk_valid), .chk_fault(chk_fault),
        .chk_hit(chk_hit), .chk_region(chk_region)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state
    logic [31:0]   m_base [NREG];
    logic [31:0]   m_attr [NREG];
    logic [RW-1:0] m_sel;
    logic          m_en;

    function automatic logic [31:0] mk(input bit en, input int code, input logic [7:0] srd,
                                       input int ap, input bit xn);
        logic [31:0] w;
        w = 32'(en) | (32'(code) << 1) | (32'(srd) << 8) | (32'(ap) << 24) | (32'(xn) << 28);
        return w;
    endfunction

    function automatic bit ap_ok(input int ap, input bit priv, input bit wr);
        case (ap)
            1: return priv;
            2: return priv || !wr;
            3: return 1'b1;
            5: return priv && !wr;
            6, 7: return !wr;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [2:0] a);
        case (a)
            3'd0: return 32'(NREG) << 8;
            3'd1: return {31'd0, m_en};
            3'd2: return 32'(m_sel);
            3'd3: return m_base[m_sel] | 32'(m_sel);
            3'd4: return m_attr[m_sel];
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // one clock cycle with the inputs already driven
    task automatic cyc(input string tag);
        bit ev, ef, eh;
        logic [RW-1:0] er;
        bit found;
        #1;
        check(tag, "rdata", reg_rdata, model_read(reg_addr));
        ev = acc_valid; ef = 0; eh = 0; er = '0;
        if (acc_valid && m_en) begin
            found = 0;
            for (int r = NREG - 1; r >= 0 && !found; r--) begin
                int code;
                logic [63:0] span;
                logic [31:0] lowm;
                int slice;
                code = int'(m_attr[r][5:1]);
                if (m_attr[r][0] && code >= 4) begin
                    span  = 64'd1 << (code + 1);
                    lowm  = 32'(span - 64'd1);
                    slice = int'((acc_addr >> (code - 2)) & 32'd7);
                    if (((acc_addr ^ m_base[r]) & ~lowm) == 32'd0 && !m_attr[r][8 + slice]) begin
                        found = 1;
                        eh = 1;
                        er = RW'(r);
                        ef = !ap_ok(int'(m_attr[r][26:24]), acc_priv, acc_write && !acc_fetch)
                             || (acc_fetch && m_attr[r][28]);
                    end
                end
            end
            if (!found) ef = 1;
        end
        if (reg_wr) begin
            case (reg_addr)
                3'd1: m_en = reg_wdata[0];
                3'd2: m_sel = reg_wdata[RW-1:0];
                3'd3: begin
                    if (reg_wdata[4]) m_sel = reg_wdata[RW-1:0];
                    m_base[m_sel] = reg_wdata & 32'hFFFF_FFE0;
                end
                3'd4: m_attr[m_sel] = reg_wdata & 32'h173F_FF3F;
                default: ;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "chk_valid", 32'(chk_valid), 32'(ev));
        check(tag, "chk_fault", 32'(chk_fault), 32'(ef));
        check(tag, "chk_hit", 32'(chk_hit), 32'(eh));
        check(tag, "chk_region", 32'(chk_region), 32'(er));
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        cyc(tag);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, input string tag);
        reg_addr = a;
        cyc(tag);
    endtask

    task automatic acc(input logic [31:0] a, input bit w, input bit f, input bit p,
                       input string tag);
        acc_valid = 1; acc_addr = a; acc_write = w; acc_fetch = f; acc_priv = p;
        cyc(tag);
        acc_valid = 0;
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        report();
    end

    initial begin
        logic [31:0] addrs [6];
        rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
        acc_valid = 0; acc_addr = 0; acc_write = 0; acc_fetch = 0; acc_priv = 0;
        for (int r = 0; r < NREG; r++) begin m_base[r] = 0; m_attr[r] = 0; end
        m_sel = 0; m_en = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // reset state and read-only words (R1, R2, R13)
        rd(3'd0, "R1");
        rd(3'd1, "R2");
        wr(3'd0, 32'hFFFF_FFFF, "R1");
        rd(3'd0, "R1");
        wr(3'd6, 32'hFFFF_FFFF, "R1");
        rd(3'd6, "R1");
        rd(3'd4, "R6");
        acc(32'h0000_1234, 1, 0, 0, "R2");
        rd(3'd0, "R13");

        // region 0: whole space, full access
        wr(3'd2, 32'd0, "R3");
        wr(3'd3, 32'd0, "R5");
        wr(3'd4, mk(1, 31, 8'h00, 3, 0), "R6");
        // region 1 via override, junk low base bits, 64 KB, slice 2 off, xn
        wr(3'd3, 32'h2000_0120 | 32'h10 | 32'd1, "R4");
        rd(3'd2, "R4");
        rd(3'd3, "R5");
        wr(3'd4, mk(1, 15, 8'h04, 1, 1), "R6");
        // region 2: 4 KB read-only
        wr(3'd2, 32'd2, "R3");
        wr(3'd3, 32'h2000_8000, "R3");
        wr(3'd4, mk(1, 11, 8'h00, 6, 0), "R6");
        // region 3: unusable size code
        wr(3'd3, 32'h2000_0000 | 32'h10 | 32'd3, "R7");
        wr(3'd4, mk(1, 3, 8'h00, 0, 0), "R7");
        // region 5: reserved bits
        wr(3'd2, 32'd5, "R3");
        wr(3'd4, 32'hFFFF_FFFE, "R6");
        rd(3'd4, "R6");
        wr(3'd2, 32'd1, "R3");
        rd(3'd4, "R3");

        acc(32'h2000_8000, 1, 0, 0, "R2");
        wr(3'd1, 32'h0000_0003, "R2");
        rd(3'd1, "R2");

        addrs[0] = 32'h1000_0000; addrs[1] = 32'h2000_0000; addrs[2] = 32'h2000_4000;
        addrs[3] = 32'h2000_8010; addrs[4] = 32'h2000_FFFC; addrs[5] = 32'h2001_0000;
        for (int i = 0; i < 6; i++)
            for (int k = 0; k < 8; k++)
                acc(addrs[i], k[0], k[1], k[2], (i == 2) ? "R9" : "R8");
        acc(32'h2000_0040, 0, 1, 1, "R12");
        acc(32'h2000_0040, 1, 1, 1, "R12");
        rd(3'd0, "R13");

        // permission code sweep on region 2 (R11)
        for (int ap = 0; ap < 8; ap++) begin
            wr(3'd2, 32'd2, "R11");
            wr(3'd4, mk(1, 11, 8'h00, ap, 0), "R11");
            for (int k = 0; k < 4; k++)
                acc(32'h2000_8ABC, k[0], 0, k[1], "R11");
        end

        // miss with region 0 off (R10)
        wr(3'd2, 32'd0, "R10");
        wr(3'd4, mk(0, 31, 8'h00, 3, 0), "R10");
        acc(32'h4000_0000, 0, 0, 1, "R10");
        acc(32'h2000_8000, 0, 0, 1, "R10");

        // smallest size (R7)
        wr(3'd3, 32'h0000_0100, "R7");
        wr(3'd4, mk(1, 4, 8'h00, 3, 0), "R7");
        acc(32'h0000_0100, 1, 0, 0, "R7");
        acc(32'h0000_011C, 1, 0, 0, "R7");
        acc(32'h0000_0120, 1, 0, 0, "R7");
        acc(32'h0000_00FC, 1, 0, 0, "R7");
        wr(3'd4, mk(1, 4, 8'h80, 3, 0), "R9");
        acc(32'h0000_011C, 1, 0, 0, "R9");

        // global off again (R2)
        wr(3'd1, 32'd0, "R2");
        acc(32'h4000_0000, 1, 1, 0, "R2");
        rd(3'd7, "R13");
        report();
    end

endmodule